// File: doc/BRIEF.md
# ATA PIO Cycle Timing Engine

This block is the host-side sequencer for single programmed-I/O accesses on a parallel ATA bus. Software loads two packed timing words and a control word through a small register port. Each request then carries an address, a direction, an access width and, for writes, the data. For each request the block runs chip select and address setup, the read or write strobe, an optional wait on IORDY, data hold and the recovery time to the next strobe. All intervals are counted in system clock cycles.

The timing fields are stored in clock cycles that have already been rounded up from nanoseconds, so no interval can fall below its minimum. Two example settings show the range. The slowest mode spans 600 ns per cycle with 70 ns setup, a 290 ns byte strobe, a 165 ns word strobe and 30 ns hold. The fastest mode spans 120 ns per cycle with 25 ns setup, 70 ns for both strobes and 10 ns hold. A request is accepted when `req_valid` and `req_ready` are both high at a clock edge. `req_ready` stays low from acceptance until the sequencer is idle again, and while the sequencer reset bit is set. A held request must keep its fields stable until it is accepted. A read result appears as a one-cycle pulse on `rsp_valid`. The response has no back-pressure, so the requester must take it in that cycle.

Top module: `ata_pio_engine`

## Requirements
- R1: After reset, `busy` is 0, `req_ready` is 1, both chip selects and both strobes are high (inactive), `ata_dd_oe` is 0 and `rsp_valid` is 0.
- R2: `cfg_sel` picks the target of a `cfg_we` write: 0 loads timing word A, 1 loads timing word B, 2 loads control. Word A holds the minimum total cycle in bits 31:24, the byte-access strobe width in 23:16, the word-access strobe width in 15:8 and the strobe recovery in 7:0. Word B holds the data hold in bits 31:24, the setup in 23:16 and the IORDY sample delay in 15:8. In the control word, bit 0 is the sequencer reset and bit 1 enables IORDY. The timing words are sampled when a request is accepted.
- R3: Chip select and address are active for exactly S cycles before the strobe goes low, where S is the setup field.
- R4: The strobe is low for W cycles. W is the word strobe width when `req_wide`=1 and the byte strobe width otherwise.
- R5: After the strobe rises, chip select and address stay active for exactly H cycles, where H is the hold field.
- R6: `busy` is high for exactly max(S+W'+max(H,R), T) cycles from the acceptance edge, where W' is the actual strobe length, R the recovery and T the minimum total cycle.
- R7: Any timing field of value 0 counts as 1 cycle.
- R8: With IORDY enabled, when strobe cycle j satisfies j>=W and j>=D (D is the sample delay) while `ata_iordy` is low, the strobe is extended by one cycle.
- R9: With IORDY disabled, `ata_iordy` has no effect on the strobe length.
- R10: A read latches `ata_dd_in` on the edge that ends the strobe. `rsp_valid` pulses in the next cycle with all 16 bits for a word access, or the low byte zero-extended for a byte access.
- R11: A write drives `ata_dd_oe`=1 from setup through hold. The driven value is the request data, with the upper byte forced to zero for a byte access. A write produces no `rsp_valid`.
- R12: `req_ready` is 0 whenever `busy` is 1. A request held during a transaction is accepted at the end of the first idle cycle.
- R13: While the sequencer reset bit is set, the sequencer is forced idle within one cycle, `req_ready` is 0 and no request is accepted. After the bit is cleared, operation resumes.
- R14: Address bit 3 selects `ata_cs1_n` (1) or `ata_cs0_n` (0), and bits 2:0 appear on `ata_da`. The two chip selects are never active together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_sel | input | 2 | Register select (0 word A, 1 word B, 2 control) |
| cfg_wdata | input | 32 | Register write data |
| req_valid | input | 1 | Request valid |
| req_ready | output | 1 | Request accepted when high with valid |
| req_addr | input | 4 | Bit 3 chip select choice, bits 2:0 register address |
| req_write | input | 1 | 1 write, 0 read |
| req_wide | input | 1 | 1 word (16-bit) access, 0 byte access |
| req_wdata | input | 16 | Write data |
| rsp_valid | output | 1 | One-cycle read data pulse |
| rsp_rdata | output | 16 | Read data |
| busy | output | 1 | Transaction in progress |
| ata_cs0_n | output | 1 | Chip select 0, active low |
| ata_cs1_n | output | 1 | Chip select 1, active low |
| ata_da | output | 3 | Device register address |
| ata_dior_n | output | 1 | Read strobe, active low |
| ata_diow_n | output | 1 | Write strobe, active low |
| ata_iordy | input | 1 | Device ready, low stretches the strobe |
| ata_dd_in | input | 16 | Data bus from device |
| ata_dd_out | output | 16 | Data bus to device |
| ata_dd_oe | output | 1 | Data bus output enable |

## Verification
Some properties are checked on every cycle. These are chip select exclusivity, the strobe being preceded by a cycle of chip select, read strobe and output enable never overlapping, `rsp_valid` following a read strobe, `req_ready` never high while busy, and the sequencer staying idle while its reset bit is held. The exact lengths of setup, strobe, hold and whole cycle cannot be checked cycle by cycle. Neither can the IORDY stretching, the zero-as-one rule, which bus sample a read captures, or the acceptance of a held request. Only the bench sweeps show these, by counting cycles across a grid of field values and comparing against arithmetic expectations.

// File: rtl/ata_pio_pkg.sv
package ata_pio_pkg;

  localparam int FIELD_W = 8;
  localparam int WORD_W  = 4 * FIELD_W;

  typedef enum logic [2:0] {
    SQ_IDLE   = 3'd0,
    SQ_SETUP  = 3'd1,
    SQ_STROBE = 3'd2,
    SQ_HOLD   = 3'd3,
    SQ_RECOV  = 3'd4
  } seq_state_t;

  // word A: total cycle, byte strobe, word strobe, recovery
  typedef struct packed {
    logic [FIELD_W-1:0] cyc_min;
    logic [FIELD_W-1:0] strobe8;
    logic [FIELD_W-1:0] strobe16;
    logic [FIELD_W-1:0] recov;
  } timing_a_t;

  // word B: hold, setup, ready sample delay, unused
  typedef struct packed {
    logic [FIELD_W-1:0] hold;
    logic [FIELD_W-1:0] setup;
    logic [FIELD_W-1:0] rdy_delay;
    logic [FIELD_W-1:0] spare;
  } timing_b_t;

  function automatic logic [FIELD_W-1:0] at_least_one(input logic [FIELD_W-1:0] v);
    return (v == '0) ? FIELD_W'(1) : v;
  endfunction

endpackage

// File: rtl/ata_pio_cfg.sv
module ata_pio_cfg
  import ata_pio_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [1:0]        cfg_sel,
  input  logic [WORD_W-1:0] cfg_wdata,
  output logic [WORD_W-1:0] tim_a,
  output logic [WORD_W-1:0] tim_b,
  output logic              smr,
  output logic              iordy_en
);

  localparam logic [1:0] SEL_A    = 2'd0;
  localparam logic [1:0] SEL_B    = 2'd1;
  localparam logic [1:0] SEL_CTRL = 2'd2;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tim_a    <= '0;
      tim_b    <= '0;
      smr      <= 1'b0;
      iordy_en <= 1'b0;
    end else if (cfg_we) begin
      case (cfg_sel)
        SEL_A:    tim_a <= cfg_wdata;
        SEL_B:    tim_b <= cfg_wdata;
        SEL_CTRL: begin
          smr      <= cfg_wdata[0];
          iordy_en <= cfg_wdata[1];
        end
        default: ;
      endcase
    end
  end

endmodule

// File: rtl/ata_pio_seq.sv
module ata_pio_seq
  import ata_pio_pkg::*;
#(
  parameter int CNT_W = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              smr,
  input  logic              iordy_en,
  input  logic              iordy,
  input  logic              start,
  input  logic              wide,
  input  logic [WORD_W-1:0] tim_a,
  input  logic [WORD_W-1:0] tim_b,
  output seq_state_t        state,
  output logic              strobe_done
);

  timing_a_t ta;
  timing_b_t tb;
  assign ta = timing_a_t'(tim_a);
  assign tb = timing_b_t'(tim_b);

  // per-transaction snapshot of the timing fields (zero already raised to one)
  logic [FIELD_W-1:0] s_strobe, s_hold, s_recov, s_delay, s_min;
  logic [FIELD_W-1:0] pcnt;   // cycles left in setup / hold after this one
  logic [FIELD_W-1:0] rcnt;   // recovery cycles left after this one
  logic [CNT_W-1:0]   scnt;   // strobe cycles elapsed before this one
  logic [CNT_W-1:0]   tcnt;   // index of the current cycle since acceptance
  logic [CNT_W-1:0]   scnt_nx, tcnt_nx;
  logic               strobe_reached, iordy_hold, leave_ok;
  logic [FIELD_W-1:0] setup_len;

  assign setup_len      = at_least_one(tb.setup);
  assign scnt_nx        = (scnt == '1) ? scnt : scnt + 1'b1;
  assign tcnt_nx        = (tcnt == '1) ? tcnt : tcnt + 1'b1;
  assign strobe_reached = scnt_nx >= CNT_W'(s_strobe);
  assign iordy_hold     = iordy_en && (scnt_nx >= CNT_W'(s_delay)) && !iordy;
  assign strobe_done    = !smr && (state == SQ_STROBE) && strobe_reached && !iordy_hold;
  assign leave_ok       = (rcnt == '0) && (tcnt >= CNT_W'(s_min));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= SQ_IDLE;
      pcnt     <= '0;
      rcnt     <= '0;
      scnt     <= '0;
      tcnt     <= '0;
      s_strobe <= FIELD_W'(1);
      s_hold   <= FIELD_W'(1);
      s_recov  <= FIELD_W'(1);
      s_delay  <= FIELD_W'(1);
      s_min    <= FIELD_W'(1);
    end else if (smr) begin
      state <= SQ_IDLE;
      pcnt  <= '0;
      rcnt  <= '0;
      scnt  <= '0;
      tcnt  <= '0;
    end else begin
      case (state)
        SQ_IDLE: begin
          if (start) begin
            state    <= SQ_SETUP;
            pcnt     <= setup_len - 1'b1;
            tcnt     <= CNT_W'(1);
            s_strobe <= at_least_one(wide ? ta.strobe16 : ta.strobe8);
            s_hold   <= at_least_one(tb.hold);
            s_recov  <= at_least_one(ta.recov);
            s_delay  <= at_least_one(tb.rdy_delay);
            s_min    <= at_least_one(ta.cyc_min);
          end
        end
        SQ_SETUP: begin
          tcnt <= tcnt_nx;
          if (pcnt == '0) begin
            state <= SQ_STROBE;
            scnt  <= '0;
          end else begin
            pcnt <= pcnt - 1'b1;
          end
        end
        SQ_STROBE: begin
          tcnt <= tcnt_nx;
          if (strobe_done) begin
            state <= SQ_HOLD;
            pcnt  <= s_hold - 1'b1;
            rcnt  <= s_recov - 1'b1;
          end else begin
            scnt <= scnt_nx;
          end
        end
        SQ_HOLD: begin
          tcnt <= tcnt_nx;
          if (rcnt != '0) rcnt <= rcnt - 1'b1;
          if (pcnt == '0) begin
            state <= leave_ok ? SQ_IDLE : SQ_RECOV;
          end else begin
            pcnt <= pcnt - 1'b1;
          end
        end
        SQ_RECOV: begin
          tcnt <= tcnt_nx;
          if (rcnt != '0) rcnt <= rcnt - 1'b1;
          if (leave_ok) state <= SQ_IDLE;
        end
        default: state <= SQ_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/ata_pio_bus.sv
module ata_pio_bus
  import ata_pio_pkg::*;
#(
  parameter int ADDR_W = 4,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              smr,
  input  logic              start,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic              req_write,
  input  logic              req_wide,
  input  logic [DATA_W-1:0] req_wdata,
  input  seq_state_t        state,
  input  logic              strobe_done,
  input  logic [DATA_W-1:0] dd_in,
  output logic [1:0]        cs_n,
  output logic [ADDR_W-2:0] da,
  output logic              dior_n,
  output logic              diow_n,
  output logic [DATA_W-1:0] dd_out,
  output logic              dd_oe,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_rdata
);

  localparam int LANE_W = DATA_W / 2;

  logic [ADDR_W-1:0] addr_q;
  logic              wr_q, wide_q;
  logic [DATA_W-1:0] wdata_q;
  logic              active;

  assign active = (state == SQ_SETUP) || (state == SQ_STROBE) || (state == SQ_HOLD);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q  <= '0;
      wr_q    <= 1'b0;
      wide_q  <= 1'b0;
      wdata_q <= '0;
    end else if (start) begin
      addr_q  <= req_addr;
      wr_q    <= req_write;
      wide_q  <= req_wide;
      wdata_q <= req_wide ? req_wdata : {{LANE_W{1'b0}}, req_wdata[LANE_W-1:0]};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
    end else if (smr) begin
      rsp_valid <= 1'b0;
    end else if (strobe_done && !wr_q) begin
      rsp_valid <= 1'b1;
      rsp_rdata <= wide_q ? dd_in : {{LANE_W{1'b0}}, dd_in[LANE_W-1:0]};
    end else begin
      rsp_valid <= 1'b0;
    end
  end

  for (genvar g = 0; g < 2; g++) begin : g_cs
    assign cs_n[g] = !(active && (addr_q[ADDR_W-1] == 1'(g)));
  end

  assign da     = addr_q[ADDR_W-2:0];
  assign dior_n = !((state == SQ_STROBE) && !wr_q);
  assign diow_n = !((state == SQ_STROBE) && wr_q);
  assign dd_oe  = active && wr_q;
  assign dd_out = dd_oe ? wdata_q : '0;

endmodule

// File: rtl/ata_pio_engine.sv
module ata_pio_engine
  import ata_pio_pkg::*;
#(
  parameter int ADDR_W = 4,
  parameter int DATA_W = 16,
  parameter int CNT_W  = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [1:0]        cfg_sel,
  input  logic [WORD_W-1:0] cfg_wdata,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic              req_write,
  input  logic              req_wide,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic              busy,
  output logic              ata_cs0_n,
  output logic              ata_cs1_n,
  output logic [ADDR_W-2:0] ata_da,
  output logic              ata_dior_n,
  output logic              ata_diow_n,
  input  logic              ata_iordy,
  input  logic [DATA_W-1:0] ata_dd_in,
  output logic [DATA_W-1:0] ata_dd_out,
  output logic              ata_dd_oe
);

  logic [WORD_W-1:0] tim_a, tim_b;
  logic              smr_q, iordy_en;
  logic              start, strobe_done;
  logic [1:0]        cs_n;
  seq_state_t        state;

  assign req_ready = (state == SQ_IDLE) && !smr_q;
  assign start     = req_valid && req_ready;
  assign busy      = (state != SQ_IDLE);
  assign ata_cs0_n = cs_n[0];
  assign ata_cs1_n = cs_n[1];

  ata_pio_cfg u_cfg (
    .clk      (clk),
    .rst_n    (rst_n),
    .cfg_we   (cfg_we),
    .cfg_sel  (cfg_sel),
    .cfg_wdata(cfg_wdata),
    .tim_a    (tim_a),
    .tim_b    (tim_b),
    .smr      (smr_q),
    .iordy_en (iordy_en)
  );

  ata_pio_seq #(.CNT_W(CNT_W)) u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .smr        (smr_q),
    .iordy_en   (iordy_en),
    .iordy      (ata_iordy),
    .start      (start),
    .wide       (req_wide),
    .tim_a      (tim_a),
    .tim_b      (tim_b),
    .state      (state),
    .strobe_done(strobe_done)
  );

  ata_pio_bus #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_bus (
    .clk        (clk),
    .rst_n      (rst_n),
    .smr        (smr_q),
    .start      (start),
    .req_addr   (req_addr),
    .req_write  (req_write),
    .req_wide   (req_wide),
    .req_wdata  (req_wdata),
    .state      (state),
    .strobe_done(strobe_done),
    .dd_in      (ata_dd_in),
    .cs_n       (cs_n),
    .da         (ata_da),
    .dior_n     (ata_dior_n),
    .diow_n     (ata_diow_n),
    .dd_out     (ata_dd_out),
    .dd_oe      (ata_dd_oe),
    .rsp_valid  (rsp_valid),
    .rsp_rdata  (rsp_rdata)
  );

endmodule

// File: rtl/ata_pio_checker.sv
module ata_pio_checker (
  input logic clk,
  input logic rst_n,
  input logic smr,
  input logic busy,
  input logic req_ready,
  input logic cs0_n,
  input logic cs1_n,
  input logic dior_n,
  input logic diow_n,
  input logic dd_oe,
  input logic rsp_valid
);

  AST_CS_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    !(!cs0_n && !cs1_n)); // R14

  AST_STROBE_AFTER_SETUP: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(dior_n) || $fell(diow_n)) |-> $past(!cs0_n || !cs1_n)); // R3

  AST_STROBE_UNDER_CS: assert property (@(posedge clk) disable iff (!rst_n)
    (!dior_n || !diow_n) |-> (!cs0_n || !cs1_n)); // R14

  AST_OE_NOT_ON_READ: assert property (@(posedge clk) disable iff (!rst_n)
    dd_oe |-> dior_n); // R11

  AST_RSP_AFTER_READ: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> ($past(!dior_n) && dior_n)); // R10

  AST_READY_ONLY_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> !busy); // R12

  AST_RESET_BIT_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (smr && $past(smr)) |-> (!busy && !req_ready && cs0_n && cs1_n)); // R13

endmodule

bind ata_pio_engine ata_pio_checker u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .smr      (smr_q),
  .busy     (busy),
  .req_ready(req_ready),
  .cs0_n    (ata_cs0_n),
  .cs1_n    (ata_cs1_n),
  .dior_n   (ata_dior_n),
  .diow_n   (ata_diow_n),
  .dd_oe    (ata_dd_oe),
  .rsp_valid(rsp_valid)
);

// File: tb/ata_pio_engine_tb.sv
module ata_pio_engine_tb;

  localparam time CLK_P = 10ns;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [1:0]  cfg_sel = '0;
  logic [31:0] cfg_wdata = '0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [3:0]  req_addr = '0;
  logic        req_write = 1'b0;
  logic        req_wide = 1'b0;
  logic [15:0] req_wdata = '0;
  logic        rsp_valid;
  logic [15:0] rsp_rdata;
  logic        busy;
  logic        ata_cs0_n, ata_cs1_n;
  logic [2:0]  ata_da;
  logic        ata_dior_n, ata_diow_n;
  logic        ata_iordy = 1'b1;
  logic [15:0] ata_dd_in = '0;
  logic [15:0] ata_dd_out;
  logic        ata_dd_oe;

  int checks = 0;
  int errors = 0;

  always #(CLK_P/2) clk = ~clk;

  ata_pio_engine u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
    .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr), .req_write(req_write),
    .req_wide(req_wide), .req_wdata(req_wdata), .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
    .busy(busy), .ata_cs0_n(ata_cs0_n), .ata_cs1_n(ata_cs1_n), .ata_da(ata_da),
    .ata_dior_n(ata_dior_n), .ata_diow_n(ata_diow_n), .ata_iordy(ata_iordy),
    .ata_dd_in(ata_dd_in), .ata_dd_out(ata_dd_out), .ata_dd_oe(ata_dd_oe)
  );

  task automatic chk(input bit ok, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", what, act, exp);
    end
  endtask

  function automatic int m1(input int v);
    return (v == 0) ? 1 : v;
  endfunction

  function automatic int imax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  // strobe length: extended while enabled, past delay and device not ready
  function automatic int strobe_len(input int w, input int d, input bit en, input int low);
    int j = w;
    while (en && j >= d && j <= low) j++;
    return j;
  endfunction

  task automatic cfg_wr(input logic [1:0] sel, input logic [31:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  // one transaction; s/w/h/r/t are expected cycle counts (w is the real strobe length)
  task automatic run_txn(input logic [3:0] addr, input bit wr, input bit wide,
                         input logic [15:0] wd, input int s, input int w, input int h,
                         input int r, input int t, input int low, input string tag);
    int k = 1, ns = 0, nw = 0, nh = 0, nb = 0, nrsp = 0, bad = 0, badrdy = 0, sidx = 0;
    bit seen = 0, csa, st, oth;
    logic [15:0] rd = '0, expd, expo;
    int expb;
    expo = wide ? wd : {8'h00, wd[7:0]};
    expd = 16'hA500 + 16'(s + w);
    if (!wide) expd = {8'h00, expd[7:0]};
    expb = imax(s + w + imax(h, r), t);
    @(negedge clk);
    req_addr = addr; req_write = wr; req_wide = wide; req_wdata = wd; req_valid = 1'b1;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    while (busy && k < 3000) begin
      csa = !ata_cs0_n || !ata_cs1_n;
      st  = wr ? !ata_diow_n : !ata_dior_n;
      oth = wr ? !ata_dior_n : !ata_diow_n;
      if (req_ready) badrdy++;
      if (rsp_valid) begin nrsp++; rd = rsp_rdata; end
      if (oth) bad++;
      if (st) begin
        sidx++; nw++; seen = 1;
        ata_iordy = (sidx > low);
      end else begin
        ata_iordy = 1'b1;
        if (csa && !seen) ns++;
        else if (csa) nh++;
      end
      if (csa) begin
        if (ata_da != addr[2:0]) bad++;
        if (ata_cs1_n != !addr[3] || ata_cs0_n != addr[3]) bad++;
        if (ata_dd_oe != wr) bad++;
        if (wr && ata_dd_out != expo) bad++;
      end else if (ata_dd_oe || st) bad++;
      ata_dd_in = 16'hA500 + 16'(k);
      nb++; k++;
      @(negedge clk);
    end
    chk(ns == s, {"R3 setup length ", tag}, ns, s);
    chk(nw == w, {"R4 R8 strobe length ", tag}, nw, w);
    chk(nh == h, {"R5 hold length ", tag}, nh, h);
    chk(nb == expb, {"R6 busy length ", tag}, nb, expb);
    chk(bad == 0, {"R11 R14 bus pins ", tag}, bad, 0);
    chk(badrdy == 0 && req_ready, {"R12 ready while busy ", tag}, badrdy, 0);
    if (wr) chk(nrsp == 0, {"R11 no response on write ", tag}, nrsp, 0);
    else begin
      chk(nrsp == 1, {"R10 response count ", tag}, nrsp, 1);
      chk(rd == expd, {"R10 read data ", tag}, int'(rd), int'(expd));
    end
  endtask

  initial begin
    #(CLK_P * 150000);
    errors++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int nb;
    int txn = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: reset state
    chk(!busy && req_ready, "R1 idle after reset", int'(busy), 0);
    chk(ata_cs0_n && ata_cs1_n && ata_dior_n && ata_diow_n, "R1 bus inactive", 0, 1);
    chk(!ata_dd_oe && !rsp_valid, "R1 no drive no response", int'(ata_dd_oe), 0);

    // R7: all timing fields zero -> every phase one cycle
    run_txn(4'h2, 1'b0, 1'b1, 16'h0, 1, 1, 1, 1, 1, 0, "R7 all zero");

    // R2 R3 R4 R5 R6 R7: sweep of field values
    for (int su = 0; su < 3; su++)
      for (int sti = 0; sti < 3; sti++)
        for (int ho = 0; ho < 2; ho++)
          for (int rc = 0; rc < 2; rc++)
            for (int tc = 0; tc < 2; tc++) begin
              int v_su = (su == 2) ? 3 : su;
              int v_st = (sti == 0) ? 0 : ((sti == 1) ? 2 : 5);
              int v_ho = ho * 2;
              int v_rc = rc ? 6 : 1;
              int v_tc = tc * 14;
              cfg_wr(2'd0, {8'(v_tc), 8'(v_st), 8'(v_st + 2), 8'(v_rc)});
              cfg_wr(2'd1, {8'(v_ho), 8'(v_su), 8'd1, 8'd0});
              for (int wide = 0; wide < 2; wide++)
                for (int wr = 0; wr < 2; wr++) begin
                  logic [3:0] a;
                  int w;
                  a = {1'(wr ^ tc), 3'(v_su + sti + ho)};
                  w = m1(wide ? v_st + 2 : v_st);
                  txn++;
                  run_txn(a, 1'(wr), 1'(wide), 16'h1234 + 16'(txn * 37),
                          m1(v_su), w, m1(v_ho), m1(v_rc), m1(v_tc), 0, "sweep R2");
                end
            end

    // R8: IORDY enabled, delay 2, device not ready for 6 strobe cycles
    cfg_wr(2'd2, 32'h2);
    cfg_wr(2'd0, {8'd0, 8'd3, 8'd3, 8'd1});
    cfg_wr(2'd1, {8'd1, 8'd1, 8'd2, 8'd0});
    run_txn(4'h3, 1'b0, 1'b0, 16'h0, 1, strobe_len(3, 2, 1'b1, 6), 1, 1, 1, 6, "R8 stretched");
    run_txn(4'hB, 1'b1, 1'b1, 16'hBEEF, 1, strobe_len(3, 2, 1'b1, 4), 1, 1, 1, 4, "R8 write stretched");
    // R8: delay beyond the strobe width, ready is never sampled
    cfg_wr(2'd1, {8'd1, 8'd1, 8'd5, 8'd0});
    run_txn(4'h3, 1'b0, 1'b0, 16'h0, 1, strobe_len(3, 5, 1'b1, 6), 1, 1, 1, 6, "R8 late delay");
    // R9: IORDY disabled, device not ready has no effect
    cfg_wr(2'd2, 32'h0);
    cfg_wr(2'd1, {8'd1, 8'd1, 8'd2, 8'd0});
    run_txn(4'h3, 1'b0, 1'b0, 16'h0, 1, 3, 1, 1, 1, 6, "R9 ignored");

    // R12: request held during a transaction is taken after the first idle cycle
    cfg_wr(2'd0, {8'd20, 8'd2, 8'd2, 8'd1});
    cfg_wr(2'd1, {8'd1, 8'd1, 8'd1, 8'd0});
    @(negedge clk);
    req_addr = 4'h1; req_write = 1'b0; req_wide = 1'b0; req_valid = 1'b1;
    @(negedge clk);
    req_addr = 4'h9;
    nb = 0;
    begin
      int bad = 0;
      while (busy && nb < 100) begin
        if (req_ready) bad++;
        nb++;
        @(negedge clk);
      end
      chk(bad == 0, "R12 held off while busy", bad, 0);
    end
    chk(nb == 20 && req_ready, "R12 first idle cycle", nb, 20);
    @(negedge clk);
    chk(busy && !ata_cs1_n && ata_da == 3'd1, "R12 held request accepted", int'(busy), 1);
    req_valid = 1'b0;
    while (busy) @(negedge clk);

    // R13: sequencer reset in the middle of a transaction
    cfg_wr(2'd1, {8'd1, 8'd2, 8'd1, 8'd0});
    @(negedge clk);
    req_addr = 4'h4; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    @(negedge clk);
    cfg_wr(2'd2, 32'h1);
    @(negedge clk);
    chk(!busy && ata_cs0_n && ata_cs1_n && ata_dior_n, "R13 forced idle", int'(busy), 0);
    chk(!req_ready, "R13 ready low while held", int'(req_ready), 0);
    req_valid = 1'b1;
    begin
      int acc = 0;
      for (int i = 0; i < 3; i++) begin
        @(negedge clk);
        if (busy || !ata_cs0_n) acc++;
      end
      chk(acc == 0, "R13 no acceptance while held", acc, 0);
    end
    req_valid = 1'b0;
    cfg_wr(2'd2, 32'h0);
    chk(req_ready && !busy, "R13 ready after release", int'(req_ready), 1);
    run_txn(4'h6, 1'b1, 1'b0, 16'hC3A5, 2, 2, 1, 1, 20, 0, "R13 resume");

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule